// File: doc/BRIEF.md
# Analog-Output Write Strobe and Overrun Monitor

This block sits in the control path of an analog-output sequencer. Write requests reach it from two sources: the sequencer's timer and the host CPU. Each request becomes a single-cycle write strobe toward the converters, together with the channel number.

A mode bit selects how the strobes are used. In shared mode, one strobe line serves every write. In split mode, the two converters sit in separate packages, and the channel's parity steers the strobe to one of two lines.

The block also keeps a loaded flag for each of the two converters. It raises a sticky overrun status when an update command reaches a converter that has received no new data since its previous update. Software clears that status with an acknowledge.

A timebase select passes the input tick through unchanged or thins it to every second tick. This divider produces a clock enable, not a derived clock. A soft-reset strobe returns the control and interrupt-enable registers to their power-on values.

The register port is a plain write/read interface. Reads are combinational, and each write takes effect at the clock edge.

Top module: `aout_strobe_ctrl`

## Requirements
- R1: After reset, both strobe lines are low, the overrun status reads 0, the control register (address 0) reads 0, the interrupt-enable register (address 3) reads 0, and the irq output is low.
- R2: Each timer or CPU write request produces exactly one strobe pulse, one clock wide, in the cycle after the request. dac_wr_chan carries the request's channel during that pulse.
- R3: With control bit 0 at 0 (shared mode), every write pulses strobe line 0 (dac_wr_stb bit 0), and strobe line 1 never pulses.
- R4: With control bit 0 at 1 (split mode), a write to an even channel pulses line 0 only, and a write to an odd channel pulses line 1 only.
- R5: When timer and CPU requests arrive in the same cycle, the timer write is strobed first. The CPU write is strobed in the following cycle.
- R6: Each converter has a loaded flag. Converter d serves the channels whose parity is d. A write sets the flag and dac_update[d] clears it. An update that finds the flag clear sets the overrun status. If a write and an update reach the same converter in the same cycle, the update sees the flag's prior value and the flag ends up set. The status register (address 2) shows overrun in bit 0 and the loaded flags of converters 0 and 1 in bits 1 and 2.
- R7: Overrun stays set until a write of 1 to bit 0 of the command register (address 1). If that acknowledge coincides with a new overrun event, the status stays set.
- R8: With control bit 1 at 0, out_tick follows in_tick. With control bit 1 at 1, only every second in_tick passes, starting with the second in_tick after the selection takes effect.
- R9: Writing 1 to bit 1 of the command register clears the control and interrupt-enable registers in the next cycle. The overrun status and the loaded flags keep their values.
- R10: irq is high exactly while the overrun status is set and bit 0 of the interrupt-enable register is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data (combinational) |
| tmr_wr_req | input | 1 | Timer-initiated converter write |
| tmr_wr_chan | input | CH_W | Channel of the timer write |
| cpu_wr_req | input | 1 | CPU-initiated converter write |
| cpu_wr_chan | input | CH_W | Channel of the CPU write |
| dac_update | input | 2 | Update command, one bit per converter |
| in_tick | input | 1 | Input timebase enable pulse |
| out_tick | output | 1 | Output timebase enable pulse |
| dac_wr_stb | output | 2 | Write strobe lines 0 and 1 |
| dac_wr_chan | output | CH_W | Channel of the current strobe |
| overrun | output | 1 | Sticky overrun status |
| irq | output | 1 | Overrun interrupt request |

## Verification
The assertions assume the CPU source raises no new request while its previous one is still held behind a timer write. In other words, CPU requests never arrive in the two cycles following a collision. The bench's driver spaces every request by at least one idle cycle, so this condition holds throughout the run.

The assertions also assume the timebase mode changes only through register writes. The bench changes the mode only between tick bursts. As a result, the check that two consecutive output ticks never appear in divided mode sees a stable mode.

// File: rtl/aout_strobe_pkg.sv
// Shared register map, bit positions and control type for the analog-output
// strobe controller. Assumes the register address is at least 2 bits wide.
package aout_strobe_pkg;

    localparam int NUM_DAC = 2;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CMD  = 2'd1,
        REG_STAT = 2'd2,
        REG_IRQ  = 2'd3
    } reg_addr_e;

    localparam int CTRL_SPLIT_BIT = 0;
    localparam int CTRL_HALF_BIT  = 1;
    localparam int CMD_ACK_BIT    = 0;
    localparam int CMD_RST_BIT    = 1;
    localparam int STAT_OVR_BIT   = 0;
    localparam int STAT_LD_LSB    = 1;

    typedef struct packed {
        logic half;
        logic split;
    } ctrl_t;

endpackage

// File: rtl/aout_ctl_regs.sv
// Register file: control (mode and timebase), command strobes (acknowledge and
// soft reset), status readback and interrupt enable.
// Assumes: combinational read data; writes take effect at the clock edge.
module aout_ctl_regs
    import aout_strobe_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               ovr,
    input  logic [NUM_DAC-1:0] loaded,
    output ctrl_t              ctrl,
    output logic               irq_en,
    output logic               err_ack,
    output logic               soft_rst
);

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t ctrl_q;
    logic  irq_en_q;
    logic  hit_ctrl, hit_cmd, hit_irq;
    logic  unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_W];

    // Address decode for write cycles.
    assign hit_ctrl = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
    assign hit_cmd  = bus_we && (bus_addr == ADDR_W'(REG_CMD));
    assign hit_irq  = bus_we && (bus_addr == ADDR_W'(REG_IRQ));

    // Self-clearing command strobes.
    assign err_ack  = hit_cmd && bus_wdata[CMD_ACK_BIT];
    assign soft_rst = hit_cmd && bus_wdata[CMD_RST_BIT];

    // Control and interrupt-enable registers, cleared by reset or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q   <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (hit_ctrl) begin
                ctrl_q.split <= bus_wdata[CTRL_SPLIT_BIT];
                ctrl_q.half  <= bus_wdata[CTRL_HALF_BIT];
            end
            if (hit_irq) begin
                irq_en_q <= bus_wdata[0];
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_CTRL): begin
                bus_rdata[CTRL_SPLIT_BIT] = ctrl_q.split;
                bus_rdata[CTRL_HALF_BIT]  = ctrl_q.half;
            end
            ADDR_W'(REG_STAT): begin
                bus_rdata[STAT_OVR_BIT] = ovr;
                bus_rdata[STAT_LD_LSB +: NUM_DAC] = loaded;
            end
            ADDR_W'(REG_IRQ): bus_rdata[0] = irq_en_q;
            default: bus_rdata = '0;
        endcase
    end

    assign ctrl   = ctrl_q;
    assign irq_en = irq_en_q;

    p_softrst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_q == '0 && !irq_en_q));

endmodule

// File: rtl/aout_wr_strobe.sv
// Write strobe generator: merges timer and CPU write requests (timer first,
// a colliding CPU write is held one cycle) and steers a one-cycle strobe to
// line 0, or in split mode to the line given by channel parity.
// Assumes: no new CPU request while a held CPU write is outstanding.
module aout_wr_strobe
    import aout_strobe_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tmr_req,
    input  logic [CH_W-1:0]    tmr_ch,
    input  logic               cpu_req,
    input  logic [CH_W-1:0]    cpu_ch,
    input  logic               split,
    output logic [NUM_DAC-1:0] stb,
    output logic [CH_W-1:0]    ch_out,
    output logic [NUM_DAC-1:0] wr_hit
);

    logic               pend_q;
    logic [CH_W-1:0]    pend_ch_q;
    logic               sel_v;
    logic [CH_W-1:0]    sel_ch;
    logic [NUM_DAC-1:0] stb_q;
    logic [CH_W-1:0]    ch_q;
    logic [NUM_DAC-1:0] line_sel;

    // Source arbitration: timer, then held CPU write, then new CPU write.
    always_comb begin
        sel_v  = 1'b0;
        sel_ch = '0;
        if (tmr_req) begin
            sel_v  = 1'b1;
            sel_ch = tmr_ch;
        end else if (pend_q) begin
            sel_v  = 1'b1;
            sel_ch = pend_ch_q;
        end else if (cpu_req) begin
            sel_v  = 1'b1;
            sel_ch = cpu_ch;
        end
    end

    // Strobe line steering by mode and channel parity.
    always_comb begin
        line_sel = '0;
        if (split) line_sel[sel_ch[0]] = 1'b1;
        else       line_sel[0]         = 1'b1;
    end

    // Per-converter write hit for the loaded-flag tracker.
    genvar d;
    generate
        for (d = 0; d < NUM_DAC; d++) begin : g_hit
            assign wr_hit[d] = sel_v && (sel_ch[0] == d[0]);
        end
    endgenerate

    // Holding slot for a CPU write displaced by a timer write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_ch_q <= '0;
        end else if (tmr_req && cpu_req) begin
            pend_q    <= 1'b1;
            pend_ch_q <= cpu_ch;
        end else if (!tmr_req) begin
            pend_q    <= 1'b0;
        end
    end

    // Registered strobe and channel outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= '0;
            ch_q  <= '0;
        end else begin
            stb_q <= sel_v ? line_sel : '0;
            if (sel_v) ch_q <= sel_ch;
        end
    end

    assign stb    = stb_q;
    assign ch_out = ch_q;

    p_no_cpu_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !cpu_req);
    p_req_gives_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_req || cpu_req) |=> (stb_q != '0));
    p_collision_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_req && cpu_req) |-> ##2 (stb_q != '0 && ch_q == $past(cpu_ch, 2)));
    p_shared_line1_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(split) |-> !stb_q[1]);
    p_single_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_q));

endmodule

// File: rtl/aout_ovr_mon.sv
// Overrun monitor: one loaded flag per converter, set by a write and cleared
// by an update; an update to an unloaded converter sets a sticky overrun that
// only an acknowledge clears (a coincident new event wins).
// Assumes: write hits and update commands are single-cycle pulses.
module aout_ovr_mon
    import aout_strobe_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DAC-1:0] wr_hit,
    input  logic [NUM_DAC-1:0] upd,
    input  logic               ack,
    output logic               ovr,
    output logic [NUM_DAC-1:0] loaded
);

    logic [NUM_DAC-1:0] ld_q;
    logic [NUM_DAC-1:0] miss;
    logic               ovr_q;

    genvar d;
    generate
        for (d = 0; d < NUM_DAC; d++) begin : g_dac
            // Update that finds this converter without fresh data.
            assign miss[d] = upd[d] && !ld_q[d];

            // Loaded flag: a write sets it (and wins over an update).
            always_ff @(posedge clk) begin
                if (!rst_n)          ld_q[d] <= 1'b0;
                else if (wr_hit[d])  ld_q[d] <= 1'b1;
                else if (upd[d])     ld_q[d] <= 1'b0;
            end
        end
    endgenerate

    // Sticky overrun status with acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= (|miss) || (ovr_q && !ack);
    end

    assign ovr    = ovr_q;
    assign loaded = ld_q;

    p_miss_sets_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(upd & ~ld_q)) |=> ovr_q);
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !ack) |=> ovr_q);
    p_write_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[0] |=> ld_q[0]);

endmodule

// File: rtl/aout_tb_en.sv
// Output timebase enable: passes the input tick through, or with the halve
// select keeps every second tick using a toggle flop (clock enable, one domain).
// Assumes: in_tick is a single-cycle enable pulse in the clk domain.
module aout_tb_en (
    input  logic clk,
    input  logic rst_n,
    input  logic half,
    input  logic in_tick,
    output logic out_tick
);

    logic phase_q;

    // Toggle on each input tick while halving; held at 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !half) phase_q <= 1'b0;
        else if (in_tick)    phase_q <= ~phase_q;
    end

    assign out_tick = in_tick && (!half || phase_q);

    p_out_needs_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> in_tick);
    p_half_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (half && out_tick) |=> !(half && out_tick));

endmodule

// File: rtl/aout_strobe_ctrl.sv
// Top level of the analog-output write strobe and overrun monitor. Wires the
// register file, strobe generator, overrun monitor and timebase enable.
// Assumes: single clock domain, synchronous active-low reset.
module aout_strobe_ctrl
    import aout_strobe_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16,
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 2) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tmr_wr_req,
    input  logic [CH_W-1:0]   tmr_wr_chan,
    input  logic              cpu_wr_req,
    input  logic [CH_W-1:0]   cpu_wr_chan,
    input  logic [1:0]        dac_update,
    input  logic              in_tick,
    output logic              out_tick,
    output logic [1:0]        dac_wr_stb,
    output logic [CH_W-1:0]   dac_wr_chan,
    output logic              overrun,
    output logic              irq
);

    ctrl_t              ctrl;
    logic               irq_en, err_ack, soft_rst, ovr;
    logic [NUM_DAC-1:0] loaded, wr_hit;

    aout_ctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .ovr(ovr), .loaded(loaded), .ctrl(ctrl), .irq_en(irq_en),
        .err_ack(err_ack), .soft_rst(soft_rst)
    );

    aout_wr_strobe #(.CH_W(CH_W)) u_stb (
        .clk, .rst_n,
        .tmr_req(tmr_wr_req), .tmr_ch(tmr_wr_chan),
        .cpu_req(cpu_wr_req), .cpu_ch(cpu_wr_chan),
        .split(ctrl.split), .stb(dac_wr_stb), .ch_out(dac_wr_chan),
        .wr_hit(wr_hit)
    );

    aout_ovr_mon u_ovr (
        .clk, .rst_n, .wr_hit(wr_hit), .upd(dac_update), .ack(err_ack),
        .ovr(ovr), .loaded(loaded)
    );

    aout_tb_en u_tb (
        .clk, .rst_n, .half(ctrl.half), .in_tick, .out_tick
    );

    assign overrun = ovr;
    assign irq     = ovr && irq_en;

    p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> overrun);

endmodule

// File: tb/tb_aout_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_aout_strobe_ctrl;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 16;
    localparam int CH_W   = 2;
    localparam int ITEM_W = 2 + CH_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tmr_wr_req = 1'b0, cpu_wr_req = 1'b0;
    logic [CH_W-1:0]   tmr_wr_chan = '0, cpu_wr_chan = '0;
    logic [1:0]        dac_update = '0;
    logic              in_tick = 1'b0;
    logic              out_tick;
    logic [1:0]        dac_wr_stb;
    logic [CH_W-1:0]   dac_wr_chan;
    logic              overrun, irq;

    int total = 0;
    int bad   = 0;
    bit split = 1'b0;
    bit done  = 1'b0;
    logic [ITEM_W-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    aout_strobe_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(4)) dut (
        .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
        .tmr_wr_req, .tmr_wr_chan, .cpu_wr_req, .cpu_wr_chan, .dac_update,
        .in_tick, .out_tick, .dac_wr_stb, .dac_wr_chan, .overrun, .irq
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] line_for(logic [CH_W-1:0] ch);
        if (split) return ch[0] ? 2'b10 : 2'b01;
        return 2'b01;
    endfunction

    // Monitor: every strobe cycle pops one expected item (R2..R5).
    always @(posedge clk) begin
        #1;
        if (rst_n && !done && dac_wr_stb != 2'b00) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected strobe", {dac_wr_stb, dac_wr_chan}, '0);
            end else begin
                logic [ITEM_W-1:0] e;
                e = exp_q.pop_front();
                check("R2-R5 strobe/chan", {dac_wr_stb, dac_wr_chan}, e);
            end
        end
    end

    task automatic bus_wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(string req, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Driver: issue writes and push the expected strobes in order.
    task automatic drive_wr(bit t, logic [CH_W-1:0] tc, bit c, logic [CH_W-1:0] cc,
                            logic [1:0] upd);
        @(negedge clk);
        tmr_wr_req = t; tmr_wr_chan = tc;
        cpu_wr_req = c; cpu_wr_chan = cc;
        dac_update = upd;
        if (t) exp_q.push_back({line_for(tc), tc});
        if (c) exp_q.push_back({line_for(cc), cc});
        @(negedge clk);
        tmr_wr_req = 1'b0; cpu_wr_req = 1'b0; dac_update = '0;
        @(negedge clk);
    endtask

    task automatic tick(string req, bit exp);
        @(negedge clk);
        in_tick = 1'b1;
        #1;
        check(req, out_tick, exp);
        @(negedge clk);
        in_tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        check("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        check("R1 stb", dac_wr_stb, 0);
        check("R1 irq", irq, 0);
        rd_chk("R1 ctrl", 2'd0, 0);
        rd_chk("R1 status", 2'd2, 0);
        rd_chk("R1 irq_en", 2'd3, 0);

        // R2/R3: shared mode, timer and CPU writes, all channels
        for (int i = 0; i < 4; i++) drive_wr(1, CH_W'(i), 0, 0, 2'b00);
        drive_wr(0, 0, 1, 2'd3, 2'b00);
        rd_chk("R6 loaded both", 2'd2, 16'h6);

        // R5: collision in shared mode
        drive_wr(1, 2'd2, 1, 2'd1, 2'b00);

        // R4: split mode
        bus_wr(2'd0, 16'h1); split = 1'b1;
        rd_chk("R4 ctrl readback", 2'd0, 16'h1);
        for (int i = 0; i < 4; i++) drive_wr(0, 0, 1, CH_W'(i), 2'b00);
        drive_wr(1, 2'd1, 0, 0, 2'b00);
        drive_wr(1, 2'd0, 1, 2'd3, 2'b00); // R5 with steering
        drive_wr(1, 2'd3, 1, 2'd2, 2'b00); // R5 reverse parity
        check("R2 queue drained", exp_q.size(), 0);

        // R6: updates with fresh data give no overrun
        drive_wr(0, 0, 0, 0, 2'b11);
        rd_chk("R6 no overrun, flags cleared", 2'd2, 16'h0);
        // R6: second update without data -> overrun
        drive_wr(0, 0, 0, 0, 2'b10);
        rd_chk("R6 overrun on stale dac1", 2'd2, 16'h1);
        check("R6 overrun pin", overrun, 1);
        // R10: irq gating
        check("R10 irq off while disabled", irq, 0);
        bus_wr(2'd3, 16'h1);
        #1 check("R10 irq on", irq, 1);
        // R7: stays set, then ack clears
        repeat (3) @(negedge clk);
        check("R7 sticky", overrun, 1);
        bus_wr(2'd1, 16'h1);
        rd_chk("R7 ack clears", 2'd2, 16'h0);
        check("R10 irq drops", irq, 0);
        // R6: write and update in the same cycle -> overrun, flag set
        drive_wr(1, 2'd0, 0, 0, 2'b01);
        rd_chk("R6 same-cycle write/update", 2'd2, 16'h3);
        bus_wr(2'd1, 16'h1);
        rd_chk("R7 ack again", 2'd2, 16'h2);
        // R7: ack coincides with a new overrun event
        drive_wr(0, 0, 0, 0, 2'b01); // clears dac0 flag (loaded)
        rd_chk("R6 clean update", 2'd2, 16'h0);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h1; dac_update = 2'b01;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0; dac_update = 2'b00;
        rd_chk("R7 new event beats ack", 2'd2, 16'h1);

        // R8: timebase
        for (int i = 0; i < 3; i++) tick("R8 pass-through", 1);
        bus_wr(2'd0, 16'h3);
        for (int i = 0; i < 6; i++) tick("R8 halved", (i % 2) == 1);
        bus_wr(2'd0, 16'h1);
        for (int i = 0; i < 2; i++) tick("R8 back to pass", 1);

        // R9: soft reset clears control and irq enable, keeps status
        bus_wr(2'd0, 16'h3);
        bus_wr(2'd1, 16'h2); split = 1'b0;
        rd_chk("R9 ctrl cleared", 2'd0, 16'h0);
        rd_chk("R9 irq_en cleared", 2'd3, 16'h0);
        rd_chk("R9 status kept", 2'd2, 16'h1);
        drive_wr(1, 2'd1, 0, 0, 2'b00); // R3 after soft reset: line 0
        rd_chk("R9 shared mode write", 2'd2, 16'h5);

        repeat (3) @(negedge clk);
        check("R2 final queue empty", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule